// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single timer channel built around one 16-bit down-counter. A host programs it over an 8-bit bus. One bus address takes a control word and the other takes the count bytes. The control word picks one of six output waveforms, binary or BCD counting, and the byte order used for count access.

The counter advances only on system clock cycles where `cnt_tick` is high; such a cycle is a "tick". The `gate` input has one of two roles, depending on the mode:
- a level enable, in the terminal-count, rate, square-wave and software-strobe modes;
- an edge trigger, in the one-shot and hardware-strobe modes. In the rate and square-wave modes a rising edge also restarts the period.

The host can freeze the running count in a read latch and then read it back byte by byte, while the counter keeps running.

Top module: `prog_interval_timer`

## Requirements
- R1: After reset `tmr_out` is low, the channel is in mode 0 with binary counting and two-byte access, and both count bytes read as 0x00.
- R2: A write with `addr`=1 is a control word. Bits [1:0] select access: 00 is a latch command, 01 low byte only, 10 high byte only, 11 low byte then high byte. Bits [4:2] select the mode, with codes 6 and 7 acting as modes 2 and 3. Bit 5 selects BCD, and bits [7:6] are ignored. A non-latch control word discards any count. It then drives `tmr_out` low for mode 0 and high for every other mode.
- R3: Count writes (`addr`=0) behave according to the access setting. Low-only fills the high byte with zero, and high-only fills the low byte with zero. Two-byte access completes on the second write. A count of zero means 65536 in binary and 10000 in BCD.
- R4: Mode 0. A completed count write drives `tmr_out` low. The first tick after the write loads N, and `tmr_out` rises on tick N+1. It stays high until the next count or control write.
- R5: Mode 0. While `gate` is low, ticks do not change the count and `tmr_out` holds. Counting resumes where it stopped once `gate` is high again.
- R6: Mode 1. The count write alone does not start the channel. The first tick after a `gate` rising edge loads N and drives `tmr_out` low; it stays low through tick N and goes high on tick N+1.
- R7: Mode 2. Counting tick 1 as the load tick, `tmr_out` is low after tick k exactly when (k-1) mod N equals N-1, and high otherwise. The count reloads by itself.
- R8: Mode 3 (N of at least 2). `tmr_out` is high after tick k exactly when (k-1) mod N is below ceil(N/2). An odd N therefore gives one more high tick than low tick.
- R9: Mode 4. `tmr_out` stays high through tick N, is low after tick N+1, and is high again from tick N+2 on. Mode 5 behaves the same, but its ticks count from the first tick after a `gate` rising edge.
- R10: Modes 2 and 3. A low `gate` drives `tmr_out` high one clock later and stops counting. After `gate` rises again, the next tick reloads N and the waveform restarts as tick 1.
- R11: With BCD selected, every decrement follows decimal digit rules. For example, 0x0010 is followed by 0x0009, 0x0100 by 0x0099, and 0x0000 by 0x9999.
- R12: A latch command captures the count. Reads then return the captured value while counting continues, until all bytes of the access setting have been read. A second latch command while a value is held is ignored.
- R13: Without a latch, reads return the live count: the low byte for low-only access, the high byte for high-only access, and low then high bytes alternately for two-byte access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Count enable; one tick per cycle where high |
| gate | input | 1 | Gate level / trigger input |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (advances the read sequence) |
| addr | input | 1 | 0 = count bytes, 1 = control word |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Selected count byte |
| tmr_out | output | 1 | Timer output waveform |

## Verification
The bench builds the block with its default 8-bit bus, which gives a 16-bit counter, and uses that build throughout. With the default width, a full zero-count run is short enough to cover completely: 65536 binary ticks and 10000 BCD ticks in mode 0. This exercises the maximum-count case end to end rather than inferring it from a single wrap step. The short directed counts (3 to 5) put every waveform's edges within a few ticks. The odd and even square-wave periods and the digit borrows of BCD decrement are checked against closed-form expectations.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_BOTH  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    M_TCINT    = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } mode_e;

  typedef struct packed {
    logic  bcd;
    mode_e mode;
    acc_e  acc;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{bcd: 1'b0, mode: M_TCINT, acc: ACC_BOTH};

  // Control word fields: [1:0] access, [4:2] mode, [5] BCD select
  function automatic cfg_t decode_ctrl(input logic [5:0] w);
    cfg_t c;
    c.acc = acc_e'(w[1:0]);
    c.bcd = w[5];
    case (w[4:2])
      3'd6:    c.mode = M_RATE;
      3'd7:    c.mode = M_SQUARE;
      default: c.mode = mode_e'(w[4:2]);
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tmr_bus.sv
module tmr_bus
  import tmr_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic               addr,
  input  logic [BUS_W-1:0]   wr_data,
  output logic [BUS_W-1:0]   rd_data,
  input  logic [2*BUS_W-1:0] cnt,
  output logic               cfg_new,
  output cfg_t               cfg,
  output logic               load_new,
  output logic [2*BUS_W-1:0] reload
);
  localparam int CNT_W = 2 * BUS_W;

  logic             wr_ff, rd_ff, latched;
  logic [BUS_W-1:0] lo_stage;
  logic [CNT_W-1:0] latch_val;

  wire  cfg_wr   = wr_en & addr;
  wire  cnt_wr   = wr_en & ~addr;
  wire  cnt_rd   = rd_en & ~addr;
  cfg_t cfg_in;
  assign cfg_in = decode_ctrl(wr_data[5:0]);
  wire  is_latch_cmd = cfg_wr & (cfg_in.acc == ACC_LATCH);

  // Read path: latched snapshot has priority over the live count
  wire [CNT_W-1:0] rd_src  = latched ? latch_val : cnt;
  wire             pick_hi = (cfg.acc == ACC_HI) || ((cfg.acc == ACC_BOTH) && rd_ff);
  assign rd_data = pick_hi ? rd_src[CNT_W-1:BUS_W] : rd_src[BUS_W-1:0];

  // Last byte of a read sequence releases the latch
  wire rd_last = cnt_rd & ((cfg.acc != ACC_BOTH) | rd_ff);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg       <= CFG_RESET;
      cfg_new   <= 1'b0;
      load_new  <= 1'b0;
      reload    <= '0;
      lo_stage  <= '0;
      wr_ff     <= 1'b0;
      rd_ff     <= 1'b0;
      latched   <= 1'b0;
      latch_val <= '0;
    end else begin
      cfg_new  <= 1'b0;
      load_new <= 1'b0;
      if (cnt_rd) begin
        if (cfg.acc == ACC_BOTH) rd_ff <= ~rd_ff;
        if (rd_last) latched <= 1'b0;
      end
      if (is_latch_cmd) begin
        if (!latched) begin
          latched   <= 1'b1;
          latch_val <= cnt;
        end
      end else if (cfg_wr) begin
        cfg     <= cfg_in;
        cfg_new <= 1'b1;
        wr_ff   <= 1'b0;
        rd_ff   <= 1'b0;
        latched <= 1'b0;
      end else if (cnt_wr) begin
        case (cfg.acc)
          ACC_LO: begin
            reload   <= {{BUS_W{1'b0}}, wr_data};
            load_new <= 1'b1;
          end
          ACC_HI: begin
            reload   <= {wr_data, {BUS_W{1'b0}}};
            load_new <= 1'b1;
          end
          default: begin
            if (!wr_ff) begin
              lo_stage <= wr_data;
              wr_ff    <= 1'b1;
            end else begin
              reload   <= {wr_data, lo_stage};
              wr_ff    <= 1'b0;
              load_new <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (rst)
    latched |=> (!latched || $stable(latch_val))); // R12
  AST_CFG_NOT_LATCH: assert property (@(posedge clk) disable iff (rst)
    cfg_new |-> (cfg.acc != ACC_LATCH)); // R2

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             gate,
  input  logic             cfg_new,
  input  cfg_t             cfg,
  input  logic             load_new,
  input  logic [CNT_W-1:0] reload,
  output logic             out,
  output logic [CNT_W-1:0] cnt
);
  localparam int               DIGITS = CNT_W / 4;
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO    = CNT_W'(2);

  // Binary or decimal-digit decrement by a small step
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v,
                                                 input logic [1:0] s,
                                                 input logic bcd);
    logic [CNT_W-1:0] r;
    logic [4:0]       d;
    logic [1:0]       bor;
    r = '0;
    if (!bcd) begin
      r = v - CNT_W'(s);
    end else begin
      bor = s;
      for (int i = 0; i < DIGITS; i++) begin
        d = {1'b0, v[4*i +: 4]} - {3'b000, bor};
        if (d[4]) begin
          d   = d + 5'd10;
          bor = 2'd1;
        end else begin
          bor = 2'd0;
        end
        r[4*i +: 4] = d[3:0];
      end
    end
    return r;
  endfunction

  logic loaded, pend, trig, armed, gate_q;

  wire is_level  = (cfg.mode == M_TCINT) || (cfg.mode == M_SWSTROBE);
  wire is_period = (cfg.mode == M_RATE) || (cfg.mode == M_SQUARE);
  wire is_edge   = (cfg.mode == M_ONESHOT) || (cfg.mode == M_HWSTROBE);
  wire is_strobe = (cfg.mode == M_SWSTROBE) || (cfg.mode == M_HWSTROBE);

  // Named internal events
  wire gate_rise = gate & ~gate_q;
  wire trig_eff  = trig | gate_rise;
  wire ev_start  = tick & (is_level  ? pend :
                           is_period ? (gate & (pend | (trig_eff & loaded))) :
                                       (trig_eff & loaded));
  wire ev_run    = tick & loaded & ~pend & ~ev_start & (is_edge | gate);

  wire [CNT_W-1:0] half_base = {reload[CNT_W-1:1], 1'b0};
  wire [CNT_W-1:0] sq_target = (out && reload[0]) ? '0 : TWO;
  wire [CNT_W-1:0] cnt_m1    = step_down(cnt, 2'd1, cfg.bcd);
  wire [CNT_W-1:0] cnt_m2    = step_down(cnt, 2'd2, cfg.bcd);

  always_ff @(posedge clk) begin
    if (rst) begin
      out    <= 1'b0;
      cnt    <= '0;
      loaded <= 1'b0;
      pend   <= 1'b0;
      trig   <= 1'b0;
      armed  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      trig   <= tick ? 1'b0 : trig_eff;
      if (cfg_new) begin
        out    <= (cfg.mode != M_TCINT);
        loaded <= 1'b0;
        pend   <= 1'b0;
        armed  <= 1'b0;
        trig   <= 1'b0;
      end else begin
        if (is_period && !gate) out <= 1'b1;
        if (is_strobe && tick && !out) out <= 1'b1;
        if (ev_start) begin
          cnt   <= (cfg.mode == M_SQUARE) ? half_base : reload;
          pend  <= 1'b0;
          armed <= 1'b1;
          case (cfg.mode)
            M_TCINT:   ;
            M_ONESHOT: out <= 1'b0;
            default:   out <= 1'b1;
          endcase
        end else if (ev_run) begin
          case (cfg.mode)
            M_TCINT: begin
              cnt <= cnt_m1;
              if (cnt == ONE) out <= 1'b1;
            end
            M_ONESHOT: begin
              cnt <= cnt_m1;
              if (cnt == ONE && armed) begin
                out   <= 1'b1;
                armed <= 1'b0;
              end
            end
            M_RATE: begin
              if (cnt == ONE) begin
                cnt <= reload;
                out <= 1'b1;
              end else begin
                cnt <= cnt_m1;
                if (cnt == TWO) out <= 1'b0;
              end
            end
            M_SQUARE: begin
              if (cnt == sq_target) begin
                out <= ~out;
                cnt <= half_base;
              end else begin
                cnt <= cnt_m2;
              end
            end
            default: begin
              cnt <= cnt_m1;
              if (out && cnt == ONE && armed) begin
                out   <= 1'b0;
                armed <= 1'b0;
              end
            end
          endcase
        end
        if (load_new) begin
          loaded <= 1'b1;
          if (is_level || (is_period && !loaded)) pend <= 1'b1;
          if (cfg.mode == M_TCINT) out <= 1'b0;
        end
      end
    end
  end

  AST_CFG_LEVEL: assert property (@(posedge clk) disable iff (rst)
    cfg_new |=> (out == (cfg.mode != M_TCINT))); // R2
  AST_TC_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == M_TCINT && out && !cfg_new && !load_new) |=> out); // R4
  AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == M_TCINT && tick && !gate && !ev_start && !cfg_new) |=> $stable(cnt)); // R5
  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == M_ONESHOT && out && !cfg_new && !ev_start) |=> out); // R6
  AST_RATE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == M_RATE && !out && tick && !cfg_new) |=> out); // R7
  AST_SQUARE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == M_SQUARE && gate && !tick && !cfg_new) |=> $stable(out)); // R8
  AST_STROBE_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
    (is_strobe && !out && tick && !cfg_new) |=> out); // R9
  AST_GATE_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (is_period && !gate && !cfg_new) |=> out); // R10

endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer
  import tmr_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_tick,
  input  logic             gate,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data,
  output logic             tmr_out
);
  localparam int CNT_W = 2 * BUS_W;

  logic             cfg_new, load_new;
  cfg_t             cfg;
  logic [CNT_W-1:0] reload, cnt;

  tmr_bus #(.BUS_W(BUS_W)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .cnt      (cnt),
    .cfg_new  (cfg_new),
    .cfg      (cfg),
    .load_new (load_new),
    .reload   (reload)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (cnt_tick),
    .gate     (gate),
    .cfg_new  (cfg_new),
    .cfg      (cfg),
    .load_new (load_new),
    .reload   (reload),
    .out      (tmr_out),
    .cnt      (cnt)
  );

  AST_RESET_LOW: assert property (@(posedge clk) rst |=> !tmr_out); // R1

endmodule

// File: tb/test_prog_interval_timer.sv
`timescale 1ns/1ps
module test_prog_interval_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       gate = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       tmr_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  prog_interval_timer i_prog_interval_timer (
    .clk(clk), .rst(rst), .cnt_tick(tick), .gate(gate),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .tmr_out(tmr_out)
  );

  function automatic logic [7:0] cw(input logic [1:0] acc, input logic [2:0] md, input logic bcd);
    return {2'b00, bcd, md, acc};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic bus_rd(output logic [7:0] b);
    @(negedge clk); addr = 1'b0; rd_en = 1'b1;
    #1 b = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    bus_rd(lo);
    bus_rd(hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic set_gate(input logic v);
    @(negedge clk); gate = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 out after reset", tmr_out, 0);
    rd16(v);
    check("R1 count after reset", v, 16'h0000);
  endtask

  task automatic t_mode0;
    set_gate(1);
    bus_wr(1, cw(2'b11, 3'd0, 0));
    check("R2 mode0 initial low", tmr_out, 0);
    bus_wr(0, 8'd5); bus_wr(0, 8'd0);
    ticks(5); check("R4 low through N", tmr_out, 0);
    ticks(1); check("R4 high at N+1", tmr_out, 1);
    ticks(3); check("R4 stays high", tmr_out, 1);
    bus_wr(0, 8'd3); bus_wr(0, 8'd0);
    check("R4 low after new count", tmr_out, 0);
  endtask

  task automatic t_gate0;
    logic [15:0] v;
    bus_wr(1, cw(2'b11, 3'd0, 0));
    bus_wr(0, 8'd4); bus_wr(0, 8'd0);
    ticks(2);
    set_gate(0);
    ticks(5); check("R5 out held while gate low", tmr_out, 0);
    bus_wr(1, 8'h00); rd16(v);
    check("R5 count frozen", v, 16'd3);
    set_gate(1);
    ticks(2); check("R5 resumes low", tmr_out, 0);
    ticks(1); check("R5 resumes to terminal", tmr_out, 1);
  endtask

  task automatic t_mode1;
    set_gate(0);
    bus_wr(1, cw(2'b11, 3'd1, 0));
    check("R2 mode1 initial high", tmr_out, 1);
    bus_wr(0, 8'd3); bus_wr(0, 8'd0);
    ticks(4); check("R6 no start without trigger", tmr_out, 1);
    set_gate(1);
    ticks(1); check("R6 low on load tick", tmr_out, 0);
    ticks(2); check("R6 low through N", tmr_out, 0);
    ticks(1); check("R6 high at N+1", tmr_out, 1);
  endtask

  task automatic t_mode2;
    int bad = 0;
    set_gate(1);
    bus_wr(1, 8'hC0 | cw(2'b11, 3'd6, 0));
    check("R2 code 6 acts as rate, high bits ignored", tmr_out, 1);
    bus_wr(0, 8'd4); bus_wr(0, 8'd0);
    for (int k = 1; k <= 9; k++) begin
      ticks(1);
      check("R7 rate waveform", tmr_out, (((k - 1) % 4) == 3) ? 16'd0 : 16'd1);
    end
    ticks(3); check("R7 pulse low", tmr_out, 0);
    set_gate(0); check("R10 gate low forces high", tmr_out, 1);
    ticks(3); check("R10 stays high while gated", tmr_out, 1);
    set_gate(1);
    ticks(3); check("R10 restart not yet low", tmr_out, 1);
    ticks(1); check("R10 restart low at N", tmr_out, 0);
    ticks(1); check("R10 restart high again", tmr_out, 1);
  endtask

  task automatic t_mode3(input int n);
    int hi_len;
    hi_len = (n + 1) / 2;
    bus_wr(1, cw(2'b11, 3'd3, 0));
    bus_wr(0, 8'(n)); bus_wr(0, 8'd0);
    for (int k = 1; k <= 2 * n; k++) begin
      ticks(1);
      check("R8 square waveform", tmr_out, (((k - 1) % n) < hi_len) ? 16'd1 : 16'd0);
    end
  endtask

  task automatic t_mode4;
    bus_wr(1, cw(2'b11, 3'd4, 0));
    check("R2 mode4 initial high", tmr_out, 1);
    bus_wr(0, 8'd3); bus_wr(0, 8'd0);
    ticks(3); check("R9 high through N", tmr_out, 1);
    ticks(1); check("R9 strobe low", tmr_out, 0);
    ticks(1); check("R9 strobe one tick", tmr_out, 1);
    ticks(4); check("R9 single strobe", tmr_out, 1);
  endtask

  task automatic t_mode5;
    set_gate(0);
    bus_wr(1, cw(2'b11, 3'd5, 0));
    bus_wr(0, 8'd3); bus_wr(0, 8'd0);
    ticks(5); check("R9 mode5 waits for trigger", tmr_out, 1);
    set_gate(1);
    ticks(3); check("R9 mode5 high through N", tmr_out, 1);
    ticks(1); check("R9 mode5 strobe low", tmr_out, 0);
    ticks(1); check("R9 mode5 strobe ends", tmr_out, 1);
  endtask

  task automatic t_bcd;
    logic [15:0] v;
    bus_wr(1, cw(2'b11, 3'd0, 1));
    bus_wr(0, 8'h10); bus_wr(0, 8'h00);
    ticks(2); bus_wr(1, 8'h00); rd16(v);
    check("R11 BCD 10 to 09", v, 16'h0009);
    bus_wr(0, 8'h00); bus_wr(0, 8'h01);
    ticks(2); bus_wr(1, 8'h00); rd16(v);
    check("R11 BCD 100 to 99", v, 16'h0099);
    bus_wr(0, 8'h00); bus_wr(0, 8'h00);
    ticks(2); bus_wr(1, 8'h00); rd16(v);
    check("R11 BCD 0 to 9999", v, 16'h9999);
  endtask

  task automatic t_access;
    logic [7:0] b;
    bus_wr(1, cw(2'b01, 3'd0, 0));
    bus_wr(0, 8'd7);
    ticks(3); bus_rd(b);
    check("R13 low-only live read", b, 8'h05);
    ticks(4); check("R3 low-only count low at N", tmr_out, 0);
    ticks(1); check("R3 low-only count done", tmr_out, 1);
    bus_wr(1, cw(2'b10, 3'd0, 0));
    bus_wr(0, 8'h01);
    ticks(1); bus_rd(b);
    check("R3 high-only gives 256", b, 8'h01);
    ticks(1); bus_rd(b);
    check("R13 high-only live read", b, 8'h00);
  endtask

  task automatic t_latch;
    logic [15:0] v;
    bus_wr(1, cw(2'b11, 3'd0, 0));
    bus_wr(0, 8'h34); bus_wr(0, 8'h12);
    ticks(1); bus_wr(1, 8'h00);
    ticks(4); rd16(v);
    check("R12 latched value", v, 16'h1234);
    rd16(v);
    check("R12 live after release", v, 16'h1230);
    bus_wr(1, 8'h00); ticks(2); bus_wr(1, 8'h00); rd16(v);
    check("R12 second latch ignored", v, 16'h1230);
  endtask

  task automatic t_zero;
    bus_wr(1, cw(2'b11, 3'd0, 0));
    bus_wr(0, 8'h00); bus_wr(0, 8'h00);
    ticks(65536); check("R3 binary zero low through 65536", tmr_out, 0);
    ticks(1); check("R3 binary zero terminal", tmr_out, 1);
    bus_wr(1, cw(2'b11, 3'd0, 1));
    bus_wr(0, 8'h00); bus_wr(0, 8'h00);
    ticks(10000); check("R3 BCD zero low through 10000", tmr_out, 0);
    ticks(1); check("R3 BCD zero terminal", tmr_out, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_gate0();
    t_mode1();
    t_mode2();
    t_mode3(5);
    t_mode3(4);
    t_mode4();
    t_mode5();
    t_bcd();
    t_access();
    t_latch();
    t_zero();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule